// File: doc/BRIEF.md
# Byte-Lane Static RAM Sequencer

This block sits between an on-chip request/response bus and an external asynchronous static RAM. The RAM holds 512K words of 24 bits and splits each word into three 8-bit lanes. Each lane has its own active-low select, so a request carries a 3-bit lane mask along with its address, write data and direction. The sequencer turns each accepted request into one timed memory cycle. Reads return a word on a one-clock response strobe.

All analog timing minimums are turned into clock counts at elaboration time, from the clock period in picoseconds and a speed-grade parameter. Three counters track the overall cycle length, the write-strobe width and the read sampling delay. A fourth counter holds the bus off until a power-up interval has passed after reset. While no access is running, the memory sits in standby with every select high.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While an access is running, select bit i (lane i = data bits 8i+7..8i) is low exactly when bit i of the accepted lane mask was 1.
- R2: After reset is released, `req_ready` stays low and rises on the PWR-th clock edge, where PWR = ceil(power-up time / clock period).
- R3: With no access running, all selects are high, `mem_we_n` and `mem_oe_n` are high, and `mem_dq_oe` is 0. A request is taken only on an edge where `req_valid` and `req_ready` are both high, and `req_ready` is high only in that standby state.
- R4: On a write, address, selects and data are presented one cycle before `mem_we_n` falls. `mem_we_n` stays low for exactly P cycles, where P = ceil(max(strobe width, data setup) / clock period). It rises one cycle or more before the selects rise and before data drive stops. `mem_oe_n` stays high throughout.
- R5: A write occupies max(P+2, C) cycles from acceptance until `req_ready` returns, where C = ceil(minimum cycle time / clock period).
- R6: On a read, the masked selects and `mem_oe_n` are low, `mem_we_n` is high, and `mem_dq_oe` is 0 for the whole access.
- R7: A read samples `mem_dq_in` on the edge max(A, C) cycles after acceptance, where A = ceil(max(address access, output-enable access) / clock period). `rsp_valid` is high for exactly one cycle after that edge.
- R8: Lanes whose mask bit was 0 return zero in `rsp_rdata`, whatever the memory bus carries on them.
- R9: A write with a partial mask changes only the masked lanes, so a later full read returns the old contents in the other lanes.
- R10: The write strobe and output enable are never low together, and the data bus is driven only while output enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and powered up |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 24 | Write data |
| req_lanes | input | 3 | Lane mask, bit i = bits 8i+7..8i |
| rsp_valid | output | 1 | Read data strobe, one cycle |
| rsp_rdata | output | 24 | Read data, unselected lanes zero |
| mem_addr | output | 19 | Memory address |
| mem_cs_n | output | 3 | Per-lane active-low selects |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_out | output | 24 | Data driven to the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 24 | Data from the memory |

## Verification
The bench's memory model puts valid data on the bus only once a read has been active for A cycles, and drives a filler pattern before that. A sequencer that samples one edge early therefore returns the filler instead of the stored word. The bench also drives filler on lanes that are not selected, so a design that fails to mask them returns nonzero bytes. It measures the write strobe width, the setup of select and address before the strobe falls, and whether the strobe rises while the lanes are still selected. It writes partial masks and reads them back, which shows whether a write disturbed lanes outside its mask. Finally, it counts the cycles until ready returns after reset and after each access, which catches a design that cuts the power-up wait or the cycle time short.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WSETUP,
        ST_WPULSE,
        ST_WHOLD,
        ST_RACCESS
    } ctl_state_e;

    // Round a time in ps up to whole clocks, never below one clock.
    function automatic int ps_to_clks(input longint t_ps, input int clk_ps);
        longint n;
        n = (t_ps + longint'(clk_ps) - 1) / longint'(clk_ps);
        return (n < 1) ? 1 : int'(n);
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_lane_timer.sv
module sram_lane_timer #(
    parameter int START_CNT = 1,
    parameter int RESET_CNT = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    localparam int TOP_CNT = (START_CNT > RESET_CNT) ? START_CNT : RESET_CNT;
    localparam int CNT_W   = (TOP_CNT < 2) ? 1 : $clog2(TOP_CNT + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = CNT_W'(START_CNT - 1);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= CNT_W'(RESET_CNT);
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/sram_lane_mask.sv
module sram_lane_mask #(
    parameter int LANES  = 3,
    parameter int LANE_W = 8
) (
    input  logic [LANES*LANE_W-1:0] raw,
    input  logic [LANES-1:0]        keep,
    output logic [LANES*LANE_W-1:0] masked
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign masked[g*LANE_W +: LANE_W] = keep[g] ? raw[g*LANE_W +: LANE_W] : '0;
    end
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
    import sram_lane_pkg::*;
#(
    parameter int ADDR_W     = 19,
    parameter int LANES      = 3,
    parameter int LANE_W     = 8,
    parameter int CLK_PS     = 10000,
    parameter int FAST_GRADE = 1,
    parameter int POWERUP_NS = 1000000
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic                      req_write,
    input  logic [ADDR_W-1:0]         req_addr,
    input  logic [LANES*LANE_W-1:0]   req_wdata,
    input  logic [LANES-1:0]          req_lanes,
    output logic                      rsp_valid,
    output logic [LANES*LANE_W-1:0]   rsp_rdata,
    output logic [ADDR_W-1:0]         mem_addr,
    output logic [LANES-1:0]          mem_cs_n,
    output logic                      mem_we_n,
    output logic                      mem_oe_n,
    output logic [LANES*LANE_W-1:0]   mem_dq_out,
    output logic                      mem_dq_oe,
    input  logic [LANES*LANE_W-1:0]   mem_dq_in
);
    localparam int DATA_W   = LANES * LANE_W;
    localparam int T_CYC_PS = (FAST_GRADE != 0) ? 8000 : 10000;
    localparam int T_PWE_PS = (FAST_GRADE != 0) ? 6000 : 7000;
    localparam int T_SD_PS  = (FAST_GRADE != 0) ? 5000 : 5500;
    localparam int T_AA_PS  = (FAST_GRADE != 0) ? 8000 : 10000;
    localparam int T_DOE_PS = 5000;
    localparam int CYC_N    = ps_to_clks(longint'(T_CYC_PS), CLK_PS);
    localparam int PWE_N    = imax(ps_to_clks(longint'(T_PWE_PS), CLK_PS),
                                   ps_to_clks(longint'(T_SD_PS), CLK_PS));
    localparam int ACC_N    = imax(ps_to_clks(longint'(T_AA_PS), CLK_PS),
                                   ps_to_clks(longint'(T_DOE_PS), CLK_PS));
    localparam int PWR_N    = ps_to_clks(longint'(POWERUP_NS) * 1000, CLK_PS);

    typedef struct packed {
        ctl_state_e          st;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   wdata;
        logic [LANES-1:0]    lanes;
        logic [LANES-1:0]    cs_n;
        logic                we_n;
        logic                oe_n;
        logic                dq_oe;
        logic [DATA_W-1:0]   rdata;
        logic                rvalid;
    } ctl_regs_t;

    ctl_regs_t r_d, r_q;

    logic              accept;
    logic              pwr_done, cyc_done, wep_done, rds_done;
    logic              cyc_start, wep_start, rds_start;
    logic [DATA_W-1:0] rd_masked;

    // Power-up hold-off: loaded at reset, never restarted.
    sram_lane_timer #(.START_CNT(PWR_N), .RESET_CNT(PWR_N)) u_pwr (
        .clk(clk), .rst_n(rst_n), .start(1'b0), .done(pwr_done)
    );
    // Overall access length.
    sram_lane_timer #(.START_CNT(CYC_N), .RESET_CNT(0)) u_cyc (
        .clk(clk), .rst_n(rst_n), .start(cyc_start), .done(cyc_done)
    );
    // Write strobe width.
    sram_lane_timer #(.START_CNT(PWE_N), .RESET_CNT(0)) u_wep (
        .clk(clk), .rst_n(rst_n), .start(wep_start), .done(wep_done)
    );
    // Read sampling delay.
    sram_lane_timer #(.START_CNT(ACC_N), .RESET_CNT(0)) u_rds (
        .clk(clk), .rst_n(rst_n), .start(rds_start), .done(rds_done)
    );

    sram_lane_mask #(.LANES(LANES), .LANE_W(LANE_W)) u_mask (
        .raw(mem_dq_in), .keep(r_q.lanes), .masked(rd_masked)
    );

    assign req_ready = (r_q.st == ST_IDLE) && pwr_done;
    assign accept    = req_valid && req_ready;
    assign cyc_start = accept;
    assign rds_start = accept && !req_write;
    assign wep_start = (r_q.st == ST_WSETUP);

    always_comb begin
        r_d        = r_q;
        r_d.rvalid = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (accept) begin
                    r_d.addr  = req_addr;
                    r_d.wdata = req_wdata;
                    r_d.lanes = req_lanes;
                    r_d.cs_n  = ~req_lanes;
                    if (req_write) begin
                        r_d.st    = ST_WSETUP;
                        r_d.dq_oe = 1'b1;
                    end else begin
                        r_d.st   = ST_RACCESS;
                        r_d.oe_n = 1'b0;
                    end
                end
            end
            ST_WSETUP: begin
                r_d.st   = ST_WPULSE;
                r_d.we_n = 1'b0;
            end
            ST_WPULSE: begin
                if (wep_done) begin
                    r_d.st   = ST_WHOLD;
                    r_d.we_n = 1'b1;
                end
            end
            ST_WHOLD: begin
                if (cyc_done) begin
                    r_d.st    = ST_IDLE;
                    r_d.cs_n  = '1;
                    r_d.dq_oe = 1'b0;
                end
            end
            ST_RACCESS: begin
                if (rds_done && cyc_done) begin
                    r_d.st     = ST_IDLE;
                    r_d.cs_n   = '1;
                    r_d.oe_n   = 1'b1;
                    r_d.rdata  = rd_masked;
                    r_d.rvalid = 1'b1;
                end
            end
            default: begin
                r_d.st    = ST_IDLE;
                r_d.cs_n  = '1;
                r_d.we_n  = 1'b1;
                r_d.oe_n  = 1'b1;
                r_d.dq_oe = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.st     <= ST_IDLE;
            r_q.cs_n   <= '1;
            r_q.we_n   <= 1'b1;
            r_q.oe_n   <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign rsp_valid  = r_q.rvalid;
    assign rsp_rdata  = r_q.rdata;
    assign mem_addr   = r_q.addr;
    assign mem_cs_n   = r_q.cs_n;
    assign mem_we_n   = r_q.we_n;
    assign mem_oe_n   = r_q.oe_n;
    assign mem_dq_out = r_q.wdata;
    assign mem_dq_oe  = r_q.dq_oe;
endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
    parameter int ADDR_W = 19,
    parameter int LANES  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [LANES-1:0]  mem_cs_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              mem_dq_oe
);
    assert_standby_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_cs_n == '1) && mem_we_n && mem_oe_n && !mem_dq_oe);

    assert_strobe_oe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_we_n && !mem_oe_n));

    assert_drive_only_oe_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    assert_setup_before_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> $stable(mem_cs_n) && $stable(mem_addr) && mem_dq_oe);

    assert_strobe_ends_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> $stable(mem_cs_n) && $stable(mem_addr) && mem_dq_oe);

    assert_rsp_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_read_no_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_dq_oe && mem_we_n);
endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_oe(mem_dq_oe)
);

// File: tb/sram_lane_ctrl_test.sv
module sram_lane_ctrl_test;
    localparam int CLK_PS = 2500;
    localparam int PWR_NS = 100;
    // Slow grade: cycle 10 ns, strobe 7 ns, setup 5.5 ns, access 10 ns.
    localparam int C_N   = (10000 + CLK_PS - 1) / CLK_PS;   // 4
    localparam int P_N   = (7000 + CLK_PS - 1) / CLK_PS;    // 3
    localparam int A_N   = (10000 + CLK_PS - 1) / CLK_PS;   // 4
    localparam int PWR_N = (PWR_NS * 1000 + CLK_PS - 1) / CLK_PS; // 40
    localparam int WR_N  = (P_N + 2 > C_N) ? P_N + 2 : C_N;
    localparam int RD_N  = (A_N > C_N) ? A_N : C_N;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic        req_ready;
    logic [18:0] req_addr = '0;
    logic [23:0] req_wdata = '0;
    logic [2:0]  req_lanes = '0;
    logic        rsp_valid;
    logic [23:0] rsp_rdata;
    logic [18:0] mem_addr;
    logic [2:0]  mem_cs_n;
    logic        mem_we_n, mem_oe_n, mem_dq_oe;
    logic [23:0] mem_dq_out;
    logic [23:0] mem_dq_in = 24'h5a5a5a;

    int n_tests = 0, n_fail = 0;
    logic [23:0] ram    [int];
    logic [23:0] shadow [int];
    logic [23:0] expq   [$];
    int  rd_active = 0;
    logic [2:0] cur_lanes = '0;

    always #5 clk = ~clk;

    sram_lane_ctrl #(.CLK_PS(CLK_PS), .FAST_GRADE(0), .POWERUP_NS(PWR_NS)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_lanes(req_lanes), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] word_of(input logic [23:0] arr [int], input int a);
        return arr.exists(a) ? arr[a] : 24'h0;
    endfunction

    function automatic logic [23:0] lane_bits(input logic [2:0] m);
        return {{8{m[2]}}, {8{m[1]}}, {8{m[0]}}};
    endfunction

    // Memory model: data valid only after A_N cycles of active read.
    always @(negedge clk) begin
        logic [23:0] w;
        if (!mem_we_n && mem_dq_oe) begin
            w = word_of(ram, int'(mem_addr));
            for (int l = 0; l < 3; l++)
                if (!mem_cs_n[l]) w[l*8 +: 8] = mem_dq_out[l*8 +: 8];
            ram[int'(mem_addr)] = w;
        end
        if (!mem_oe_n && mem_we_n && mem_cs_n != 3'b111) rd_active = rd_active + 1;
        else rd_active = 0;
        w = word_of(ram, int'(mem_addr));
        for (int l = 0; l < 3; l++)
            mem_dq_in[l*8 +: 8] = (rd_active >= A_N && !mem_cs_n[l]) ? w[l*8 +: 8] : 8'ha5;
    end

    // Write-protocol monitor.
    logic       prev_we = 1'b1;
    logic [2:0] prev_cs = 3'b111;
    logic [18:0] prev_addr = '0;
    int         low_run = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!mem_we_n && prev_we) begin
                check(prev_cs == mem_cs_n && prev_addr == mem_addr && mem_dq_oe,
                      "R4 setup before strobe", {29'd0, prev_cs}, {29'd0, mem_cs_n});
                check(mem_cs_n == ~cur_lanes, "R1 write selects",
                      {29'd0, mem_cs_n}, {29'd0, ~cur_lanes});
            end
            if (!mem_we_n) begin
                low_run++;
                if (!mem_oe_n) check(0, "R4 oe during write", 0, 1);
            end
            if (mem_we_n && !prev_we) begin
                check(low_run == P_N, "R4 strobe width", low_run, P_N);
                check(mem_cs_n == prev_cs && mem_dq_oe, "R4 strobe ends first",
                      {29'd0, mem_cs_n}, {29'd0, prev_cs});
                low_run = 0;
            end
        end
        prev_we = mem_we_n; prev_cs = mem_cs_n; prev_addr = mem_addr;
    end

    // Response scoreboard.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (expq.size() == 0) check(0, "R7 unexpected response", 1, 0);
            else begin
                logic [23:0] e;
                e = expq.pop_front();
                check(rsp_rdata == e, "R8 R9 read data", rsp_rdata, e);
            end
        end
    end

    task automatic issue(input bit wr, input logic [18:0] a, input logic [23:0] d,
                         input logic [2:0] m);
        int n;
        do @(negedge clk); while (!req_ready);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_lanes = m;
        cur_lanes = m;
        if (wr) begin
            shadow[int'(a)] = (word_of(shadow, int'(a)) & ~lane_bits(m)) | (d & lane_bits(m));
        end else begin
            expq.push_back(word_of(shadow, int'(a)) & lane_bits(m));
        end
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        if (wr) begin
            while (!req_ready && n < 100) begin n++; @(negedge clk); end
            check(n == WR_N, "R5 write occupancy", n, WR_N);
        end else begin
            check(mem_cs_n == ~m && !mem_oe_n && mem_we_n && !mem_dq_oe,
                  "R6 R1 read pins", {28'd0, mem_oe_n, mem_cs_n}, {29'd0, ~m});
            while (!rsp_valid && n < 100) begin n++; @(negedge clk); end
            check(n == RD_N, "R7 read sample edge", n, RD_N);
            @(negedge clk);
            check(!rsp_valid, "R7 single strobe", {31'd0, rsp_valid}, 0);
            check(mem_cs_n == 3'b111 && mem_oe_n, "R3 standby after read",
                  {29'd0, mem_cs_n}, 7);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        check(0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        check(mem_cs_n == 3'b111 && mem_we_n && mem_oe_n && !mem_dq_oe && !req_ready && !rsp_valid,
              "R3 reset state", {25'd0, mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, req_ready, rsp_valid},
              {25'd0, 3'b111, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0});
        rst_n = 1'b1;
        n = 0;
        forever begin
            @(negedge clk);
            if (req_ready) break;
            if (mem_cs_n != 3'b111) check(0, "R3 standby in power-up", {29'd0, mem_cs_n}, 7);
            n++;
        end
        // ready rises on edge PWR_N: PWR_N-1 low samples after release.
        check(n == PWR_N - 1, "R2 power-up wait", n, PWR_N - 1);

        issue(1, 19'h00010, 24'hc0ffee, 3'b111);
        issue(0, 19'h00010, 24'h0, 3'b111);
        issue(1, 19'h00010, 24'h123456, 3'b010);      // R9 lane 1 only
        issue(0, 19'h00010, 24'h0, 3'b111);
        issue(0, 19'h00010, 24'h0, 3'b101);           // R8 lane 1 zero
        issue(1, 19'h7ffff, 24'habcdef, 3'b100);
        issue(1, 19'h7ffff, 24'h998877, 3'b001);
        issue(0, 19'h7ffff, 24'h0, 3'b111);
        issue(0, 19'h7ffff, 24'h0, 3'b010);           // R8 all-zero word
        issue(0, 19'h7ffff, 24'h0, 3'b100);
        issue(1, 19'h00000, 24'h010203, 3'b111);
        issue(0, 19'h00000, 24'h0, 3'b001);
        issue(0, 19'h00000, 24'h0, 3'b000);           // R1 no lane selected
        issue(0, 19'h00000, 24'h0, 3'b111);

        repeat (5) @(negedge clk);
        check(expq.size() == 0, "R7 all responses seen", expq.size(), 0);
        check(mem_cs_n == 3'b111 && mem_we_n && mem_oe_n && !mem_dq_oe && req_ready,
              "R3 idle standby", {29'd0, mem_cs_n}, 7);
        finish_run();
    end
endmodule